// File: doc/BRIEF.md
# Bus Target Claim Responder

This block sits on the target side of a shared, multi-drop parallel bus whose control lines are active low. It watches for the first clock edge on which the cycle-start line is sampled low after an idle bus. At that edge it captures the claim decision for the transaction. That decision rests on two checks: the address on the shared address/data lines must fall inside a programmable base/mask window, and the command must be one the block accepts. The block then pulls its device-select drive low after a selectable decode delay: one, two or three edges.

In subtractive mode it is the bus's catch-all target. It takes any accepted transaction that misses its window, but only when no other target has pulled the shared device-select line low by the fourth edge. Its own claim then becomes visible on the following edge. A claim is held until the bus goes idle. The select line is then driven high for one cycle before it is released. The ready and stop drives never leave the high level, because data transfer lies outside this block.

Top module: `tdr_target_decode`

## Requirements
- R1: The claim decision uses only the address and command present at the start edge (the first edge where `cyc_n` is sampled 0 after an edge where both `cyc_n` and `init_rdy_n` were sampled 1); address values on later edges have no effect.
- R2: An address hits when `(addr_data & dec_mask) == (dec_base & dec_mask)`; bits where the mask is 0 are ignored.
- R3: With `speed_sel` = 0 (fast) and a hit, `sel_drive_n` is 0 and `sel_oe` is 1 right after the start edge (edge 1).
- R4: With `speed_sel` = 1 (medium) and a hit, the claim appears right after edge 2.
- R5: With `speed_sel` = 2 (slow) or 3 (reserved, treated as slow) and a hit, the claim appears right after edge 3.
- R6: With `sub_en` = 1 and an accepted command that misses the window, the claim appears right after edge 4 when `sel_bus_n` was sampled 1 on edges 2, 3 and 4; a hit with `sub_en` = 1 still claims at its speed setting.
- R7: A subtractive claim is abandoned if `sel_bus_n` is sampled 0 on any of edges 2, 3 or 4.
- R8: A miss with `sub_en` = 0 produces no claim: `sel_drive_n` stays 1 and `sel_oe` stays 0.
- R9: Once claimed, `sel_drive_n` stays 0 until an edge samples `cyc_n` and `init_rdy_n` both 1. After that edge it is 1 with `sel_oe` still 1 for one cycle, and then `sel_oe` returns to 0.
- R10: `tgt_rdy_n` and `tgt_stop_n` are always 1.
- R11: During reset `sel_drive_n` is 1, `sel_oe` is 0, and `tgt_rdy_n` and `tgt_stop_n` are 1.
- R12: A command whose bit in parameter `CMD_ACCEPT` is 0 is never claimed, positively or subtractively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_n | input | 1 | Transaction-in-progress line from the initiator, active low |
| init_rdy_n | input | 1 | Initiator ready line, active low |
| addr_data | input | ADDR_W | Shared address/data lines |
| cmd_in | input | CMD_W | Command lines, valid at the start edge |
| sel_bus_n | input | 1 | Device-select line as seen on the bus, active low |
| dec_base | input | ADDR_W | Base of the decode window |
| dec_mask | input | ADDR_W | Compare mask of the decode window |
| speed_sel | input | 2 | Claim delay: 0 fast, 1 medium, 2 slow, 3 slow |
| sub_en | input | 1 | Enables subtractive claiming |
| sel_drive_n | output | 1 | Device-select drive value, active low |
| sel_oe | output | 1 | Output enable for the device-select driver |
| tgt_rdy_n | output | 1 | Target-ready drive, held high |
| tgt_stop_n | output | 1 | Stop drive, held high |

## Verification
Counting from the start edge as edge 1, a fast claim shows up after edge 1. Medium shows up after edge 2, slow or reserved after edge 3, and subtractive after edge 4. The release to a high drive follows the first edge that samples an idle bus, and the enable drops one edge later. The driver steps the bus once per cycle on the falling clock. With each step it queues the select drive and enable expected just after the next rising edge. The monitor compares them two nanoseconds after that edge, so every expected value is tied to one exact edge count.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

   typedef enum logic [1:0] {
      SPD_FAST = 2'd0,
      SPD_MED  = 2'd1,
      SPD_SLOW = 2'd2,
      SPD_RSVD = 2'd3
   } speed_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_DECODE = 3'd1,
      ST_CLAIM  = 3'd2,
      ST_TURN   = 3'd3,
      ST_WAIT   = 3'd4
   } tstate_e;

   localparam int LAT_W   = 3;
   localparam logic [LAT_W-1:0] LAT_NONE = 3'd0;
   localparam logic [LAT_W-1:0] LAT_SUB  = 3'd4;

   // edge number (counting the start edge as 1) on which a positive claim is registered
   function automatic logic [LAT_W-1:0] claim_edge(input logic [1:0] spd);
      case (spd)
         SPD_FAST: claim_edge = 3'd1;
         SPD_MED:  claim_edge = 3'd2;
         default:  claim_edge = 3'd3;
      endcase
   endfunction

endpackage

// File: rtl/tdr_addr_match.sv
module tdr_addr_match #(
   parameter int ADDR_W        = 32,
   parameter bit MASKED_DECODE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] mask,
   output logic              hit
);

   generate
      if (MASKED_DECODE) begin : g_masked
         logic [ADDR_W-1:0] diff;
         assign diff = (addr ^ base) & mask;
         assign hit  = (diff == '0);
      end else begin : g_exact
         logic unused_mask;
         assign unused_mask = ^mask;
         assign hit = (addr == base);
      end
   endgenerate

endmodule

// File: rtl/tdr_claim_timer.sv
module tdr_claim_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             sel_bus_n,
   output logic [CNT_W-1:0] edge_cnt,
   output logic             other_seen
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt   <= '0;
         other_seen <= 1'b0;
      end else if (start) begin
         edge_cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
         other_seen <= 1'b0;
      end else if (run) begin
         if (edge_cnt != CNT_MAX)
            edge_cnt <= edge_cnt + 1'b1;
         other_seen <= other_seen | ~sel_bus_n;
      end
   end

endmodule

// File: rtl/tdr_target_decode.sv
module tdr_target_decode
   import tdr_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int CMD_W         = 4,
   parameter bit MASKED_DECODE = 1'b1,
   parameter logic [(1<<CMD_W)-1:0] CMD_ACCEPT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_n,
   input  logic              init_rdy_n,
   input  logic [ADDR_W-1:0] addr_data,
   input  logic [CMD_W-1:0]  cmd_in,
   input  logic              sel_bus_n,
   input  logic [ADDR_W-1:0] dec_base,
   input  logic [ADDR_W-1:0] dec_mask,
   input  logic [1:0]        speed_sel,
   input  logic              sub_en,
   output logic              sel_drive_n,
   output logic              sel_oe,
   output logic              tgt_rdy_n,
   output logic              tgt_stop_n
);

   localparam int CNT_W = LAT_W;

   if (ADDR_W < 2) begin : g_chk_addr
      $error("tdr_target_decode: ADDR_W must be at least 2");
   end
   if (CMD_W < 1 || CMD_W > 8) begin : g_chk_cmd
      $error("tdr_target_decode: CMD_W must be 1..8");
   end

   tstate_e          state, state_nx;
   logic             bus_idle_q, bus_idle_now, start;
   logic             addr_hit, cmd_ok, hit_live, sub_live;
   logic [LAT_W-1:0] lat_live, lat_q;
   logic             hit_q, sub_q;
   logic [CNT_W-1:0] edge_cnt;
   logic             other_seen;

   assign bus_idle_now = cyc_n & init_rdy_n;
   assign start = bus_idle_q & ~cyc_n & ((state == ST_IDLE) | (state == ST_TURN));

   tdr_addr_match #(
      .ADDR_W       (ADDR_W),
      .MASKED_DECODE(MASKED_DECODE)
   ) u_match (
      .addr(addr_data),
      .base(dec_base),
      .mask(dec_mask),
      .hit (addr_hit)
   );

   assign cmd_ok   = CMD_ACCEPT[cmd_in];
   assign hit_live = addr_hit & cmd_ok;
   assign sub_live = ~addr_hit & cmd_ok & sub_en;

   always_comb begin
      if (hit_live)      lat_live = claim_edge(speed_sel);
      else if (sub_live) lat_live = LAT_SUB;
      else               lat_live = LAT_NONE;
   end

   tdr_claim_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .run       (state == ST_DECODE),
      .sel_bus_n (sel_bus_n),
      .edge_cnt  (edge_cnt),
      .other_seen(other_seen)
   );

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE, ST_TURN: begin
            if (start) begin
               if (lat_live == LAT_NONE)               state_nx = ST_WAIT;
               else if (lat_live == claim_edge(SPD_FAST)) state_nx = ST_CLAIM;
               else                                    state_nx = ST_DECODE;
            end else begin
               state_nx = ST_IDLE;
            end
         end
         ST_DECODE: begin
            if (bus_idle_now) begin
               state_nx = ST_IDLE;
            end else if (edge_cnt == lat_q - 1'b1) begin
               if (lat_q == LAT_SUB && (other_seen || !sel_bus_n))
                  state_nx = ST_WAIT;
               else
                  state_nx = ST_CLAIM;
            end
         end
         ST_CLAIM: if (bus_idle_now) state_nx = ST_TURN;
         ST_WAIT:  if (bus_idle_now) state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bus_idle_q <= 1'b1;
         lat_q      <= LAT_NONE;
         hit_q      <= 1'b0;
         sub_q      <= 1'b0;
      end else begin
         state      <= state_nx;
         bus_idle_q <= bus_idle_now;
         if (start) begin
            lat_q <= lat_live;
            hit_q <= hit_live;
            sub_q <= sub_live;
         end
      end
   end

   assign sel_drive_n = (state != ST_CLAIM);
   assign sel_oe      = (state == ST_CLAIM) | (state == ST_TURN);
   assign tgt_rdy_n   = 1'b1;
   assign tgt_stop_n  = 1'b1;

   AST_CLAIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_drive_n && !(cyc_n && init_rdy_n)) |=> !sel_drive_n); // R9
   AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_drive_n && cyc_n && init_rdy_n) |=> (sel_drive_n && sel_oe)); // R9
   AST_OE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_drive_n |-> sel_oe); // R9
   AST_CLAIM_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_drive_n) |-> (hit_q || sub_q)); // R8
   AST_SUB_NOT_CONTESTED: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sel_drive_n) && !hit_q) |-> $past(sel_bus_n)); // R7
   AST_SUB_ON_EDGE4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sel_drive_n) && !hit_q) |-> ($past(edge_cnt) == 3'd3)); // R6

endmodule

// File: tb/tdr_target_decode_test.sv
module tdr_target_decode_test;

   localparam logic [31:0] BASE = 32'hA000_0000;
   localparam logic [31:0] MASK = 32'hFFF0_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_n = 1'b1, init_rdy_n = 1'b1, sel_bus_n = 1'b1, sub_en = 1'b0;
   logic [31:0] addr_data = '0;
   logic [3:0]  cmd_in = 4'h6;
   logic [1:0]  speed_sel = 2'd0;
   logic        sel_drive_n, sel_oe, tgt_rdy_n, tgt_stop_n;

   always #4 clk = ~clk;

   tdr_target_decode #(.ADDR_W(32), .CMD_W(4), .MASKED_DECODE(1'b1),
                       .CMD_ACCEPT(16'hFFFE)) uut (
      .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .init_rdy_n(init_rdy_n),
      .addr_data(addr_data), .cmd_in(cmd_in), .sel_bus_n(sel_bus_n),
      .dec_base(BASE), .dec_mask(MASK), .speed_sel(speed_sel), .sub_en(sub_en),
      .sel_drive_n(sel_drive_n), .sel_oe(sel_oe),
      .tgt_rdy_n(tgt_rdy_n), .tgt_stop_n(tgt_stop_n));

   typedef struct {
      logic  drv_n;
      logic  oe;
      string tag;
   } exp_t;

   exp_t q[$];
   int   vectors = 0, miscompares = 0;
   bit   done = 1'b0;

   // monitor: one expected item per rising edge, compared 2 ns after it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            vectors++;
            if (sel_drive_n !== e.drv_n || sel_oe !== e.oe ||
                tgt_rdy_n !== 1'b1 || tgt_stop_n !== 1'b1) begin
               miscompares++;
               $display("FAIL %s/R10 t=%0t: drv_n=%b oe=%b rdy_n=%b stop_n=%b expected drv_n=%b oe=%b rdy_n=1 stop_n=1",
                        e.tag, $time, sel_drive_n, sel_oe, tgt_rdy_n, tgt_stop_n, e.drv_n, e.oe);
            end
         end
      end
   end

   task automatic step(input logic f, input logic ir, input logic [31:0] a,
                       input logic sb, input logic ed, input logic eo, input string tag);
      @(negedge clk);
      cyc_n = f; init_rdy_n = ir; addr_data = a; sel_bus_n = sb;
      q.push_back('{drv_n: ed, oe: eo, tag: tag});
   endtask

   // one transaction; lat = edge after which the claim is expected (0 = none),
   // other = first edge on which another target's select is sampled low (0 = never)
   task automatic txn(input logic [31:0] a, input logic [1:0] spd, input logic sub,
                      input logic [3:0] cmd, input int other, input int lat,
                      input int extra, input string tag);
      bit claimed;
      speed_sel = spd; sub_en = sub; cmd_in = cmd;
      for (int k = 1; k <= 5 + extra; k++) begin
         claimed = (lat != 0) && (k >= lat);
         step(1'b0, (k == 1) ? 1'b1 : 1'b0, (k == 1) ? a : BASE,
              (other != 0 && k >= other) ? 1'b0 : 1'b1, !claimed, claimed, tag);
      end
      claimed = (lat != 0);
      step(1'b1, 1'b0, BASE, (other != 0) ? 1'b0 : 1'b1, !claimed, claimed, tag);
      step(1'b1, 1'b1, '0, 1'b1, 1'b1, claimed, tag);
      step(1'b1, 1'b1, '0, 1'b1, 1'b1, 1'b0, tag);
   endtask

   initial begin
      // R11: outputs while reset is held
      step(1'b1, 1'b1, '0, 1'b1, 1'b1, 1'b0, "R11");
      step(1'b1, 1'b1, '0, 1'b1, 1'b1, 1'b0, "R11");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 1'b1, '0, 1'b1, 1'b1, 1'b0, "R11");

      txn(32'hA001_2344, 2'd0, 1'b0, 4'h6, 0, 1, 0, "R3");
      txn(32'hA001_2344, 2'd1, 1'b0, 4'h7, 0, 2, 0, "R4");
      txn(32'hA003_0000, 2'd2, 1'b0, 4'h6, 0, 3, 0, "R5");
      txn(32'hA003_0000, 2'd3, 1'b0, 4'h6, 0, 3, 0, "R5");
      // R1: miss at the start edge, matching address on later edges
      txn(32'hB000_0000, 2'd0, 1'b0, 4'h6, 0, 0, 0, "R8_R1");
      txn(32'hA010_0000, 2'd0, 1'b0, 4'h6, 0, 0, 0, "R2");
      txn(32'hA00F_FFFC, 2'd0, 1'b0, 4'h6, 0, 1, 0, "R2");
      txn(32'h1234_5678, 2'd0, 1'b1, 4'h6, 0, 4, 0, "R6");
      txn(32'hA000_0010, 2'd1, 1'b1, 4'h6, 0, 2, 0, "R6");
      txn(32'h1234_5678, 2'd0, 1'b1, 4'h6, 2, 0, 0, "R7");
      txn(32'h1234_5678, 2'd0, 1'b1, 4'h6, 3, 0, 0, "R7");
      txn(32'h1234_5678, 2'd0, 1'b1, 4'h6, 4, 0, 0, "R7");
      txn(32'hA001_2344, 2'd0, 1'b0, 4'h0, 0, 0, 0, "R12");
      txn(32'h1234_5678, 2'd0, 1'b1, 4'h0, 0, 0, 0, "R12");
      txn(32'hA001_2344, 2'd2, 1'b0, 4'h6, 0, 3, 4, "R9");

      wait (q.size() == 0);
      @(posedge clk);
      #3;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule